// File: doc/BRIEF.md
# Synchronous Block Frame Detector

This block watches a continuous serial bit stream that has no per-character start or stop bits. Bits arrive on a one-bit input and are taken only on cycles where a bit-valid strobe is high. Recovering the bit clock happens upstream and is not part of this block. Bits enter a byte window least-significant bit first. While hunting, the block compares that window against a block-start pattern at every bit position.

Once the pattern is found, byte alignment is fixed at the bit that follows the pattern's last bit. From then on the block delivers whole data bytes with a one-cycle valid strobe until it recognises the block-end pattern, and then it goes back to hunting. A mode input selects one of two framing styles:

- **Character framing:** the block is bracketed by sync characters of value 0x16.
- **Bit-run framing:** the block opens with a long run of ones closed by a single zero, and it ends on an all-ones byte.

Single-cycle pulses mark the start and the end of each block, so a downstream consumer can delimit blocks without decoding the framing itself. Framing costs only a few bytes per block rather than extra bits on every character. Checking the block contents, bit stuffing and clock recovery are left to other blocks.

Top module: `sync_block_framer`

## Requirements
- R1: A synchronous active-high reset clears dataValid, blockStart, blockEnd and dataOut to 0 and puts the block in the hunt state. No data is output after a reset until a complete new preamble has been received.
- R2: Bits are assembled least-significant bit first: the first bit received after the alignment point becomes bit 0 of the byte. Data bytes appear on dataOut in the order they were sent, each one with a dataValid pulse of one cycle.
- R3: In character mode (modeBits=0), the hunt compares a sliding 8-bit window with 0x16 after every accepted bit. After a match, the following bytes are read on that alignment. Further 0x16 bytes in the preamble are discarded, and the first byte that is not 0x16 is the first data byte.
- R4: In character mode, two consecutive aligned 0x16 bytes inside a block form the postamble, and neither of them is output. A single 0x16 between other data bytes is output as data.
- R5: In bit-run mode (modeBits=1), a preamble is at least MIN_ONES (default 15) consecutive 1 bits followed by a 0. Byte alignment starts at the bit after that 0. A run of ones shorter than MIN_ONES starts no block.
- R6: In bit-run mode, an aligned data byte of 0xFF is the postamble. It is not output, and the block returns to the hunt state.
- R7: blockStart pulses for one cycle when a preamble completes, before any data byte of that block is output. In character mode this is the cycle after the first non-0x16 byte has completed. In bit-run mode it is the cycle after the terminating 0.
- R8: blockEnd pulses for one cycle, in the cycle after the last postamble bit. Every data byte of the block has been output before this pulse or together with it, and the block is then in the hunt state.
- R9: Cycles with bitValid low are ignored whatever the value on bitIn. A dataValid, blockStart or blockEnd pulse only follows a cycle in which bitValid was high.
- R10: While hunting, no dataValid is produced, whatever bytes arrive.
- R11: In character mode, each data byte is held back by one byte. It appears the cycle after the last bit of the next aligned byte, so the block can tell a lone 0x16 from a postamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modeBits | input | 1 | 0 selects character framing, 1 selects bit-run framing |
| bitValid | input | 1 | High when bitIn carries a new bit |
| bitIn | input | 1 | Serial data bit |
| dataOut | output | DATA_W | Received data byte |
| dataValid | output | 1 | One-cycle strobe marking dataOut valid |
| blockStart | output | 1 | One-cycle pulse when a preamble completes |
| blockEnd | output | 1 | One-cycle pulse when a postamble completes |

## Verification
The assertions take for granted that modeBits changes only while the block is hunting. They also assume that the transmitter never puts a framing pattern into the data: no two adjacent 0x16 bytes and no 0x16 as the last data byte in character mode, and no 0xFF data byte in bit-run mode.

The stimulus generator rewrites any random data byte that would break these rules, and it switches the mode only in the idle gap of zeros between blocks. The idle filler and junk bytes are chosen so that no sliding window of them forms a preamble. Random gaps of idle cycles, with random values on bitIn, are mixed between valid bits.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } huntState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic alignReset;  // restart the bit counter at the next bit
    logic holdLoad;    // capture the completed byte into the hold register
    logic holdClear;   // drop the hold register contents
    logic emitHeld;    // output the held byte
    logic emitNew;     // output the byte completing now
  } dpCtrl_t;

endpackage

// File: rtl/sbf_datapath.sv
module sbf_datapath
  import sbf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SYN_BYTE = 'h16,
  parameter int MIN_ONES = 15,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitValid,
  input  logic              bitIn,
  input  dpCtrl_t           ctrl,
  output logic              byteDone,
  output logic              synHit,
  output logic              postHit,
  output logic              onesLock,
  output logic              heldValid,
  output logic              heldIsSyn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  localparam int CNT_W  = $clog2(DATA_W);
  localparam int ONES_W = $clog2(MIN_ONES + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(MIN_ONES);

  logic [DATA_W-1:0] win;
  logic [DATA_W-1:0] nextWin;
  logic [CNT_W-1:0]  bitCnt;
  logic [ONES_W-1:0] onesCnt;
  logic [DATA_W-1:0] held;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign nextWin = {bitIn, win[DATA_W-1:1]};
    end else begin : g_msb
      assign nextWin = {win[DATA_W-2:0], bitIn};
    end
  endgenerate

  assign byteDone  = bitValid && (bitCnt == LAST_BIT);
  assign synHit    = (nextWin == SYN_BYTE);
  assign postHit   = &nextWin;
  assign onesLock  = bitValid && !bitIn && (onesCnt == ONES_MAX);
  assign heldIsSyn = (held == SYN_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      win    <= '0;
      bitCnt <= '0;
    end else if (bitValid) begin
      win    <= nextWin;
      bitCnt <= ctrl.alignReset ? '0 : bitCnt + 1'b1;
    end
  end

  // Saturating count of consecutive ones
  always_ff @(posedge clk) begin
    if (rst) begin
      onesCnt <= '0;
    end else if (bitValid) begin
      if (!bitIn) onesCnt <= '0;
      else if (onesCnt != ONES_MAX) onesCnt <= onesCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.holdClear) begin
      heldValid <= 1'b0;
      held      <= '0;
    end else if (ctrl.holdLoad) begin
      heldValid <= 1'b1;
      held      <= nextWin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= ctrl.emitHeld || ctrl.emitNew;
      if (ctrl.emitHeld)     dataOut <= held;
      else if (ctrl.emitNew) dataOut <= nextWin;
    end
  end

  // R9
  byte_edge_chk: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> ($past(bitValid) && ($past(bitCnt) == LAST_BIT)));

endmodule

// File: rtl/sbf_control.sv
module sbf_control
  import sbf_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    modeBits,
  input  logic    bitValid,
  input  logic    byteDone,
  input  logic    synHit,
  input  logic    postHit,
  input  logic    onesLock,
  input  logic    heldValid,
  input  logic    heldIsSyn,
  output dpCtrl_t ctrl,
  output logic    hunting,
  output logic    blockStart,
  output logic    blockEnd
);

  huntState_t state, nextState;
  logic startNow, endNow;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    startNow  = 1'b0;
    endNow    = 1'b0;
    unique case (state)
      ST_HUNT: begin
        if (modeBits) begin
          if (onesLock) begin
            ctrl.alignReset = 1'b1;
            startNow        = 1'b1;
            nextState       = ST_DATA;
          end
        end else if (bitValid && synHit) begin
          ctrl.alignReset = 1'b1;
          nextState       = ST_PRE;
        end
      end
      ST_PRE: begin
        if (byteDone && !synHit) begin
          ctrl.holdLoad = 1'b1;
          startNow      = 1'b1;
          nextState     = ST_DATA;
        end
      end
      ST_DATA: begin
        if (byteDone) begin
          if (modeBits) begin
            if (postHit) begin
              endNow    = 1'b1;
              nextState = ST_HUNT;
            end else begin
              ctrl.emitNew = 1'b1;
            end
          end else if (heldValid && heldIsSyn && synHit) begin
            ctrl.holdClear = 1'b1;
            endNow         = 1'b1;
            nextState      = ST_HUNT;
          end else begin
            ctrl.emitHeld = heldValid;
            ctrl.holdLoad = 1'b1;
          end
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HUNT;
      blockStart <= 1'b0;
      blockEnd   <= 1'b0;
    end else begin
      state      <= nextState;
      blockStart <= startNow;
      blockEnd   <= endNow;
    end
  end

  assign hunting = (state == ST_HUNT);

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    blockStart |=> !blockStart);

  // R8
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    blockEnd |=> !blockEnd);

endmodule

// File: rtl/sync_block_framer.sv
module sync_block_framer
  import sbf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] SYN_BYTE = 'h16,
  parameter int MIN_ONES = 15,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeBits,
  input  logic              bitValid,
  input  logic              bitIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              blockStart,
  output logic              blockEnd
);

  dpCtrl_t ctrl;
  logic byteDone, synHit, postHit, onesLock, heldValid, heldIsSyn, hunting;

  sbf_datapath #(
    .DATA_W(DATA_W), .SYN_BYTE(SYN_BYTE),
    .MIN_ONES(MIN_ONES), .LSB_FIRST(LSB_FIRST)
  ) u_dp (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn), .ctrl(ctrl),
    .byteDone(byteDone), .synHit(synHit), .postHit(postHit),
    .onesLock(onesLock), .heldValid(heldValid), .heldIsSyn(heldIsSyn),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  sbf_control u_ctl (
    .clk(clk), .rst(rst), .modeBits(modeBits), .bitValid(bitValid),
    .byteDone(byteDone), .synHit(synHit), .postHit(postHit),
    .onesLock(onesLock), .heldValid(heldValid), .heldIsSyn(heldIsSyn),
    .ctrl(ctrl), .hunting(hunting),
    .blockStart(blockStart), .blockEnd(blockEnd)
  );

  // R10
  hunt_silent_chk: assert property (@(posedge clk) disable iff (rst)
    hunting |=> !dataValid);

  // R8
  end_hunt_chk: assert property (@(posedge clk) disable iff (rst)
    blockEnd |-> hunting);

endmodule

// File: tb/sync_block_framer_test.sv
module sync_block_framer_test;

  localparam logic [7:0] SYN = 8'h16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeBits = 1'b0;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic [7:0] dataOut;
  logic dataValid, blockStart, blockEnd;

  int total = 0, bad = 0;
  int gotCnt = 0, startSeen = 0, endSeen = 0, expStart = 0, expEnd = 0;
  bit inBlk = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] txQ[$];

  always #4 clk = ~clk;

  sync_block_framer uut (
    .clk(clk), .rst(rst), .modeBits(modeBits), .bitValid(bitValid),
    .bitIn(bitIn), .dataOut(dataOut), .dataValid(dataValid),
    .blockStart(blockStart), .blockEnd(blockEnd)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (blockStart) begin
        chk("R7 start inside block", int'(inBlk), 0);
        inBlk = 1'b1;
        startSeen++;
      end
      if (dataValid) begin
        gotCnt++;
        chk("R10 data outside block", int'(inBlk), 1);
        if (expQ.size() == 0) chk("R2 unexpected byte", int'(dataOut), -1);
        else chk("R2 data byte", int'(dataOut), int'(expQ.pop_front()));
      end
      if (blockEnd) begin
        chk("R8 pending bytes at end", expQ.size(), 0);
        inBlk = 1'b0;
        endSeen++;
      end
    end
  end

  task automatic sendBit(input logic b, input int gapMax);
    int g;
    @(negedge clk);
    bitValid = 1'b1;
    bitIn = b;
    g = (gapMax > 0) ? int'($urandom % 32'(gapMax + 1)) : 0;
    repeat (g) begin
      @(negedge clk);
      bitValid = 1'b0;
      bitIn = 1'($urandom);
    end
  endtask

  task automatic sendByte(input logic [7:0] v, input int gapMax);
    for (int i = 0; i < 8; i++) sendBit(v[i], gapMax);
  endtask

  task automatic stopDrive();
    @(negedge clk);
    bitValid = 1'b0;
    bitIn = 1'b0;
  endtask

  function automatic logic [7:0] pickData(input logic bitMode, input bit edgeSyn);
    logic [7:0] v;
    v = 8'($urandom);
    if (bitMode) begin
      if (v == 8'hFF) v = 8'h5A;
    end else begin
      if (!edgeSyn && ($urandom % 6 == 0)) v = SYN;
      if (edgeSyn && v == SYN) v = 8'h3C;
    end
    return v;
  endfunction

  task automatic fillRandom(input logic bitMode, input int n);
    txQ.delete();
    for (int i = 0; i < n; i++) begin
      bit edgeSyn;
      edgeSyn = (i == 0) || (i == n - 1) || (txQ.size() > 0 && txQ[$] == SYN);
      txQ.push_back(pickData(bitMode, edgeSyn));
    end
  endtask

  task automatic checkFrame(input string tag);
    repeat (4) @(negedge clk);
    chk({tag, " R7 start count"}, startSeen, expStart);
    chk({tag, " R8 end count"}, endSeen, expEnd);
    chk({tag, " R2 bytes left"}, expQ.size(), 0);
  endtask

  task automatic charFrame(input int nPre, input int gap);
    modeBits = 1'b0;
    sendByte(8'h00, gap);
    repeat (nPre) sendByte(SYN, gap);
    foreach (txQ[i]) begin
      expQ.push_back(txQ[i]);
      sendByte(txQ[i], gap);
    end
    sendByte(SYN, gap);
    sendByte(SYN, gap);
    sendByte(8'h00, gap);
    stopDrive();
    expStart++;
    expEnd++;
    checkFrame("char");
  endtask

  task automatic bitFrame(input int nFF, input int gap);
    modeBits = 1'b1;
    sendByte(8'h00, gap);
    repeat (nFF) sendByte(8'hFF, gap);
    sendByte(8'h7F, gap);
    foreach (txQ[i]) begin
      expQ.push_back(txQ[i]);
      sendByte(txQ[i], gap);
    end
    sendByte(8'hFF, gap);
    sendByte(8'h00, gap);
    stopDrive();
    expStart++;
    expEnd++;
    checkFrame("bit");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dataValid", int'(dataValid), 0);
    chk("R1 blockStart", int'(blockStart), 0);
    chk("R1 blockEnd", int'(blockEnd), 0);
    chk("R1 dataOut", int'(dataOut), 0);

    // R10 junk while hunting
    modeBits = 1'b0;
    repeat (6) sendByte(8'hAA, 1);
    stopDrive();
    repeat (3) @(negedge clk);
    chk("R10 no data from junk", gotCnt, 0);
    chk("R10 no start from junk", startSeen, 0);

    // R4 lone SYN in data, R3 single SYN preamble
    txQ = '{8'h41, SYN, 8'h42, 8'h43};
    charFrame(1, 0);
    // R3 several SYN preamble bytes discarded
    txQ = '{8'h81, 8'h7E, SYN, 8'h01};
    charFrame(3, 2);

    // R11 one-byte hold in character mode
    modeBits = 1'b0;
    sendByte(8'h00, 0);
    sendByte(SYN, 0);
    expQ.push_back(8'h41);
    expQ.push_back(8'h42);
    g0 = gotCnt;
    sendByte(8'h41, 0);
    stopDrive();
    repeat (3) @(negedge clk);
    chk("R11 first byte held", gotCnt, g0);
    sendByte(8'h42, 0);
    stopDrive();
    @(negedge clk);
    chk("R11 held byte out after next", gotCnt, g0 + 1);
    sendByte(SYN, 0);
    sendByte(SYN, 0);
    stopDrive();
    expStart++;
    expEnd++;
    checkFrame("hold");
    chk("R11 all bytes out", gotCnt, g0 + 2);

    // R5 short run of ones: no block
    modeBits = 1'b1;
    sendByte(8'h00, 1);
    for (int i = 0; i < 14; i++) sendBit(1'b1, 1);
    sendBit(1'b0, 1);
    sendByte(8'h00, 1);
    sendByte(8'h00, 1);
    stopDrive();
    repeat (3) @(negedge clk);
    chk("R5 short run ignored", startSeen, expStart);

    // R5 R6 bit-run frames with minimum and longer runs
    txQ = '{8'h00, 8'hFE, 8'h7F, 8'h16};
    bitFrame(1, 0);
    fillRandom(1'b1, 6);
    bitFrame(3, 3);

    // R1 reset in mid block
    modeBits = 1'b0;
    sendByte(8'h00, 0);
    sendByte(SYN, 0);
    expQ.push_back(8'h41);
    sendByte(8'h41, 0);
    sendByte(8'h42, 0);
    stopDrive();
    repeat (2) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    inBlk = 1'b0;
    expStart++;
    chk("R1 prior byte delivered", expQ.size(), 0);
    g0 = gotCnt;
    sendByte(8'h55, 1);
    sendByte(8'h43, 1);
    sendByte(8'h55, 1);
    stopDrive();
    repeat (3) @(negedge clk);
    chk("R1 silent after reset", gotCnt, g0);
    chk("R1 no start after reset", startSeen, expStart);
    chk("R1 no end after reset", endSeen, expEnd);

    // R9 random frames, mixed modes and gaps
    for (int f = 0; f < 24; f++) begin
      logic m;
      int gp;
      m = 1'($urandom);
      gp = int'($urandom % 4);
      fillRandom(m, 1 + int'($urandom % 12));
      if (m) bitFrame(1 + int'($urandom % 3), gp);
      else charFrame(1 + int'($urandom % 3), gp);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule